// File: doc/BRIEF.md
# Interrupt Domain Register Front End

This block sits between a 32-bit register bus and a bank of per-source interrupt gateways. It decodes each bus access by byte offset. Configuration state that belongs to the domain as a whole is held here: the domain enable, a mode code and a routing target for each source, and one stored message word. Pending and enable flags live in the gateway bank. For those, the block turns each write into one-cycle set or clear masks with one bit per source, and it builds 32-bit status words from the flags the bank reports.

Source identity 0 does not exist, so the source-configuration and target arrays begin at source 1. Register k of either array controls source k+1. Every bit-vector array holds ceil(NUM_IDS/32) words. The block accepts aligned 4-byte accesses only. Any other access, or an offset that maps to nothing, gets an error response and changes nothing. After each write that completes without error, a downstream delivery scanner receives a single-cycle rescan pulse.

The controller has three states. ST_IDLE: ready for a request. A valid request moves it to ST_RESP, where the response and any gateway masks are shown for exactly one cycle. From ST_RESP it goes to ST_KICK if the request was an error-free write, and otherwise back to ST_IDLE. ST_KICK raises the rescan pulse and always returns to ST_IDLE.

Top module: `irq_reg_frontend`

## Requirements
- R1: An access is answered with rsp_err=1, rdata 0, no gateway mask, no configuration change and no rescan in three cases: req_size is not 4, req_off[1:0] is nonzero, or the offset is unmapped. Unmapped includes array elements past the last one.
- R2: A read of offset 0x0000 returns 0x80000004 with bit 8 set to the stored domain enable. A write to it changes only that enable, taken from wdata bit 8.
- R3: A source-configuration write at offset 0x0004+4k acts on source k+1, for k from 0 to NUM_IDS-2. If wdata bit 10 is 1, the stored mode becomes 0. Otherwise it becomes wdata[2:0]. A read returns the stored mode.
- R4: A target write at offset 0x3004+4k acts on source k+1 and stores wdata AND 0xFFFFF7FF. This keeps [31:18], [17:12] and [10:0]. A read returns the stored value.
- R5: A read of set-pending word w (0x1C00+4w) returns the pending flags of sources 32w..32w+31 in bits 0..31. A read of set-enable word w (0x1E00+4w) returns the enable flags the same way. Clear-enable words (0x1F00+4w) and all numbered registers read 0. Source 0 and sources at or above NUM_IDS read as 0.
- R6: A read of clear-pending word w (0x1D00+4w) returns rectified inputs. A source with mode 0 gives 0. Mode 5 or 7 gives the inverted raw level. Any other mode gives the raw level.
- R7: A write of set-pending, clear-pending, set-enable or clear-enable word w (bases 0x1C00, 0x1D00, 0x1E00, 0x1F00) drives a mask on the matching gw_* output during the response cycle only. Bit i of wdata sets mask bit 32w+i. Zero bits and source 0 are never driven.
- R8: A write to a numbered register puts a one-hot mask on its gw_* output for the source number wdata: set-pending at 0x1CDC, clear-pending at 0x1DDC, set-enable at 0x1EDC, clear-enable at 0x1FDC, little-endian set-pending at 0x2000. A value of 0, or NUM_IDS or above, drives no bit and is not an error.
- R9: A write to 0x2004 byte-swaps wdata before using it as a set-pending source number.
- R10: Each word array has ceil(NUM_IDS/32) words. The first offset past the end gives an error.
- R11: req_ready is high only in ST_IDLE. The response is valid exactly one cycle after acceptance. rescan pulses for one cycle right after the response of an error-free write, and never otherwise.
- R12: A write to 0x3000 stores wdata with bits [17:12] cleared. A read of 0x3000 returns the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | OFF_W | Byte offset within the register window |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Read data |
| gw_set_pend | output | NUM_IDS | One-cycle set-pending mask |
| gw_clr_pend | output | NUM_IDS | One-cycle clear-pending mask |
| gw_set_en | output | NUM_IDS | One-cycle set-enable mask |
| gw_clr_en | output | NUM_IDS | One-cycle clear-enable mask |
| gw_pend | input | NUM_IDS | Pending flags from the gateway bank |
| gw_en | input | NUM_IDS | Enable flags from the gateway bank |
| gw_raw | input | NUM_IDS | Raw input levels from the gateway bank |
| cfg_ie | output | 1 | Domain enable |
| cfg_mode | output | NUM_IDS*3 | Mode code of each source, 3 bits each |
| cfg_target | output | NUM_IDS*32 | Target word of each source |
| rescan | output | 1 | Rescan pulse to the delivery scanner |

## Verification
Some properties are checked by assertions on every cycle. A response follows each acceptance after exactly one cycle. Gateway masks are silent outside the response cycle and never touch source 0. A numbered write drives at most one mask bit. An error response leaves all configuration untouched. The rescan pulse comes only after an error-free response. The domain enable holds through writes to other registers.

Other behaviours need the bench's scenarios, because they depend on values chosen outside the block. These are the decoded offset of every array, including the first offset past each end. They also cover the rectification for each mode, the byte swap of the big-endian register, the masked target and message fields, and the read-back of gateway flags.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;

    typedef enum logic [3:0] {
        RG_NONE, RG_DOMCFG, RG_SRCCFG, RG_SETIP, RG_SETIPNUM, RG_CLRIP,
        RG_CLRIPNUM, RG_SETIE, RG_SETIENUM, RG_CLRIE, RG_CLRIENUM,
        RG_IPNUM_LE, RG_IPNUM_BE, RG_GENMSG, RG_TARGET
    } region_e;

    typedef enum logic [1:0] {ST_IDLE, ST_RESP, ST_KICK} fe_state_e;

    localparam logic [31:0] OFF_DOMCFG   = 32'h0000;
    localparam logic [31:0] OFF_SRCCFG   = 32'h0004;
    localparam logic [31:0] OFF_SETIP    = 32'h1C00;
    localparam logic [31:0] OFF_SETIPNUM = 32'h1CDC;
    localparam logic [31:0] OFF_CLRIP    = 32'h1D00;
    localparam logic [31:0] OFF_CLRIPNUM = 32'h1DDC;
    localparam logic [31:0] OFF_SETIE    = 32'h1E00;
    localparam logic [31:0] OFF_SETIENUM = 32'h1EDC;
    localparam logic [31:0] OFF_CLRIE    = 32'h1F00;
    localparam logic [31:0] OFF_CLRIENUM = 32'h1FDC;
    localparam logic [31:0] OFF_IPNUM_LE = 32'h2000;
    localparam logic [31:0] OFF_IPNUM_BE = 32'h2004;
    localparam logic [31:0] OFF_GENMSG   = 32'h3000;
    localparam logic [31:0] OFF_TARGET   = 32'h3004;

    localparam logic [31:0] DOMCFG_FIXED = 32'h8000_0004;
    localparam int          DOMCFG_IE_BIT = 8;
    localparam int          SRCCFG_DELEG_BIT = 10;
    localparam logic [31:0] TARGET_KEEP  = 32'hFFFF_F7FF;
    localparam logic [31:0] GENMSG_KEEP  = 32'hFFFC_0FFF;

    localparam logic [2:0]  MODE_OFF  = 3'd0;
    localparam logic [2:0]  MODE_FALL = 3'd5;
    localparam logic [2:0]  MODE_LOW  = 3'd7;

    function automatic logic [31:0] bswap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

endpackage

// File: rtl/irqfe_decode.sv
module irqfe_decode
    import irqfe_pkg::*;
#(
    parameter int NUM_IDS = 40,
    parameter int OFF_W   = 14,
    parameter int IDX_W   = 6
) (
    input  logic [OFF_W-1:0] off,
    output region_e          region,
    output logic [IDX_W-1:0] idx
);
    localparam int WORDS = (NUM_IDS + 31) / 32;
    localparam logic [31:0] SRC_SPAN  = 32'((NUM_IDS - 1) * 4);
    localparam logic [31:0] WORD_SPAN = 32'(WORDS * 4);

    logic [31:0] o;
    logic [31:0] rel;

    function automatic logic in_arr(input logic [31:0] a, input logic [31:0] base,
                                    input logic [31:0] span);
        return (a >= base) && (a < base + span);
    endfunction

    always_comb begin
        o      = 32'(off);
        rel    = '0;
        region = RG_NONE;
        if (o == OFF_DOMCFG) begin
            region = RG_DOMCFG;
        end else if (in_arr(o, OFF_SRCCFG, SRC_SPAN)) begin
            region = RG_SRCCFG;
            rel    = ((o - OFF_SRCCFG) >> 2) + 32'd1;
        end else if (in_arr(o, OFF_SETIP, WORD_SPAN)) begin
            region = RG_SETIP;
            rel    = (o - OFF_SETIP) >> 2;
        end else if (o == OFF_SETIPNUM) begin
            region = RG_SETIPNUM;
        end else if (in_arr(o, OFF_CLRIP, WORD_SPAN)) begin
            region = RG_CLRIP;
            rel    = (o - OFF_CLRIP) >> 2;
        end else if (o == OFF_CLRIPNUM) begin
            region = RG_CLRIPNUM;
        end else if (in_arr(o, OFF_SETIE, WORD_SPAN)) begin
            region = RG_SETIE;
            rel    = (o - OFF_SETIE) >> 2;
        end else if (o == OFF_SETIENUM) begin
            region = RG_SETIENUM;
        end else if (in_arr(o, OFF_CLRIE, WORD_SPAN)) begin
            region = RG_CLRIE;
            rel    = (o - OFF_CLRIE) >> 2;
        end else if (o == OFF_CLRIENUM) begin
            region = RG_CLRIENUM;
        end else if (o == OFF_IPNUM_LE) begin
            region = RG_IPNUM_LE;
        end else if (o == OFF_IPNUM_BE) begin
            region = RG_IPNUM_BE;
        end else if (o == OFF_GENMSG) begin
            region = RG_GENMSG;
        end else if (in_arr(o, OFF_TARGET, SRC_SPAN)) begin
            region = RG_TARGET;
            rel    = ((o - OFF_TARGET) >> 2) + 32'd1;
        end
        idx = rel[IDX_W-1:0];
    end

    // R3: per-source arrays never decode to source 0 or past the last source
    always_comb begin
        assert_idx_range_R3: assert (!(region == RG_SRCCFG || region == RG_TARGET)
                                     || (idx != '0 && 32'(idx) < NUM_IDS));
    end

endmodule

// File: rtl/irqfe_cfgstore.sv
module irqfe_cfgstore
    import irqfe_pkg::*;
#(
    parameter int NUM_IDS = 40,
    parameter int IDX_W   = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  region_e                 region,
    input  logic [IDX_W-1:0]        idx,
    input  logic [31:0]             wdata,
    output logic                    ie,
    output logic [31:0]             genmsg,
    output logic [NUM_IDS*3-1:0]    mode_flat,
    output logic [NUM_IDS*32-1:0]   target_flat,
    output logic [2:0]              rd_mode,
    output logic [31:0]             rd_target
);
    logic        ie_q;
    logic [31:0] genmsg_q;
    logic [2:0]  mode_q   [NUM_IDS];
    logic [31:0] target_q [NUM_IDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q     <= 1'b0;
            genmsg_q <= '0;
            for (int s = 0; s < NUM_IDS; s++) begin
                mode_q[s]   <= '0;
                target_q[s] <= '0;
            end
        end else if (wr_en) begin
            if (region == RG_DOMCFG) ie_q <= wdata[DOMCFG_IE_BIT];
            if (region == RG_GENMSG) genmsg_q <= wdata & GENMSG_KEEP;
            for (int s = 1; s < NUM_IDS; s++) begin
                if (idx == IDX_W'(s)) begin
                    if (region == RG_SRCCFG)
                        mode_q[s] <= wdata[SRCCFG_DELEG_BIT] ? MODE_OFF : wdata[2:0];
                    if (region == RG_TARGET)
                        target_q[s] <= wdata & TARGET_KEEP;
                end
            end
        end
    end

    for (genvar s = 0; s < NUM_IDS; s++) begin : g_flat
        assign mode_flat[s*3 +: 3]    = mode_q[s];
        assign target_flat[s*32 +: 32] = target_q[s];
    end

    assign ie        = ie_q;
    assign genmsg    = genmsg_q;
    assign rd_mode   = (32'(idx) < NUM_IDS) ? mode_q[idx]   : 3'd0;
    assign rd_target = (32'(idx) < NUM_IDS) ? target_q[idx] : 32'd0;

    // R2: the domain enable is touched only by writes that decode to it
    assert_ie_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && region == RG_DOMCFG)) |=> $stable(ie_q));

endmodule

// File: rtl/irqfe_status.sv
module irqfe_status
    import irqfe_pkg::*;
#(
    parameter int NUM_IDS = 40,
    parameter int IDX_W   = 6
) (
    input  logic [NUM_IDS-1:0]   pend_i,
    input  logic [NUM_IDS-1:0]   en_i,
    input  logic [NUM_IDS-1:0]   raw_i,
    input  logic [NUM_IDS*3-1:0] mode_flat,
    input  logic [IDX_W-1:0]     word,
    output logic [31:0]          pend_word,
    output logic [31:0]          en_word,
    output logic [31:0]          rect_word
);
    localparam int WORDS = (NUM_IDS + 31) / 32;
    localparam int PAD   = WORDS * 32;

    logic [NUM_IDS-1:0] rect;
    logic [PAD-1:0]     pend_pad, en_pad, rect_pad;

    for (genvar s = 0; s < NUM_IDS; s++) begin : g_rect
        logic [2:0] m;
        assign m = mode_flat[s*3 +: 3];
        assign rect[s] = (m == MODE_OFF) ? 1'b0 :
                         ((m == MODE_FALL || m == MODE_LOW) ? ~raw_i[s] : raw_i[s]);
    end

    always_comb begin
        pend_pad = '0;
        en_pad   = '0;
        rect_pad = '0;
        pend_pad[NUM_IDS-1:0] = pend_i;
        en_pad[NUM_IDS-1:0]   = en_i;
        rect_pad[NUM_IDS-1:0] = rect;
        pend_pad[0] = 1'b0;
        en_pad[0]   = 1'b0;
        rect_pad[0] = 1'b0;
        if (32'(word) < WORDS) begin
            pend_word = pend_pad[32'(word)*32 +: 32];
            en_word   = en_pad[32'(word)*32 +: 32];
            rect_word = rect_pad[32'(word)*32 +: 32];
        end else begin
            pend_word = '0;
            en_word   = '0;
            rect_word = '0;
        end
    end

endmodule

// File: rtl/irq_reg_frontend.sv
module irq_reg_frontend
    import irqfe_pkg::*;
#(
    parameter int NUM_IDS = 40,
    parameter int OFF_W   = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [OFF_W-1:0]      req_off,
    input  logic [3:0]            req_size,
    input  logic [31:0]           req_wdata,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [31:0]           rsp_rdata,
    output logic [NUM_IDS-1:0]    gw_set_pend,
    output logic [NUM_IDS-1:0]    gw_clr_pend,
    output logic [NUM_IDS-1:0]    gw_set_en,
    output logic [NUM_IDS-1:0]    gw_clr_en,
    input  logic [NUM_IDS-1:0]    gw_pend,
    input  logic [NUM_IDS-1:0]    gw_en,
    input  logic [NUM_IDS-1:0]    gw_raw,
    output logic                  cfg_ie,
    output logic [NUM_IDS*3-1:0]  cfg_mode,
    output logic [NUM_IDS*32-1:0] cfg_target,
    output logic                  rescan
);
    localparam int IDX_W = $clog2(NUM_IDS);

    fe_state_e          state_q, state_d;
    region_e            dec_region;
    logic [IDX_W-1:0]   dec_idx;
    logic               accept, bad, commit, is_num;
    logic [31:0]        num_val, rd_data;
    logic [NUM_IDS-1:0] word_hit, num_hit;
    logic [NUM_IDS-1:0] sp_d, cp_d, se_d, ce_d;
    logic [31:0]        genmsg, rd_target, pend_word, en_word, rect_word;
    logic [2:0]         rd_mode;
    logic               err_q, wr_q, num_q;
    logic [31:0]        rdata_q;

    irqfe_decode #(.NUM_IDS(NUM_IDS), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_decode (
        .off(req_off), .region(dec_region), .idx(dec_idx));

    assign accept = req_valid && (state_q == ST_IDLE);
    assign bad    = (req_size != 4'd4) || (req_off[1:0] != 2'b00) || (dec_region == RG_NONE);
    assign commit = accept && req_write && !bad;

    irqfe_cfgstore #(.NUM_IDS(NUM_IDS), .IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(commit), .region(dec_region), .idx(dec_idx),
        .wdata(req_wdata), .ie(cfg_ie), .genmsg(genmsg), .mode_flat(cfg_mode),
        .target_flat(cfg_target), .rd_mode(rd_mode), .rd_target(rd_target));

    irqfe_status #(.NUM_IDS(NUM_IDS), .IDX_W(IDX_W)) u_status (
        .pend_i(gw_pend), .en_i(gw_en), .raw_i(gw_raw), .mode_flat(cfg_mode),
        .word(dec_idx), .pend_word(pend_word), .en_word(en_word), .rect_word(rect_word));

    assign num_val = (dec_region == RG_IPNUM_BE) ? bswap32(req_wdata) : req_wdata;

    for (genvar s = 0; s < NUM_IDS; s++) begin : g_mask
        if (s == 0) begin : g_zero
            assign word_hit[s] = 1'b0;
            assign num_hit[s]  = 1'b0;
        end else begin : g_src
            assign word_hit[s] = (dec_idx == IDX_W'(s / 32)) && req_wdata[s % 32];
            assign num_hit[s]  = (num_val == 32'(s));
        end
    end

    assign is_num = (dec_region == RG_SETIPNUM) || (dec_region == RG_CLRIPNUM) ||
                    (dec_region == RG_SETIENUM) || (dec_region == RG_CLRIENUM) ||
                    (dec_region == RG_IPNUM_LE) || (dec_region == RG_IPNUM_BE);

    always_comb begin
        sp_d = '0;
        cp_d = '0;
        se_d = '0;
        ce_d = '0;
        if (commit) begin
            unique case (dec_region)
                RG_SETIP:                               sp_d = word_hit;
                RG_SETIPNUM, RG_IPNUM_LE, RG_IPNUM_BE:  sp_d = num_hit;
                RG_CLRIP:                               cp_d = word_hit;
                RG_CLRIPNUM:                            cp_d = num_hit;
                RG_SETIE:                               se_d = word_hit;
                RG_SETIENUM:                            se_d = num_hit;
                RG_CLRIE:                               ce_d = word_hit;
                RG_CLRIENUM:                            ce_d = num_hit;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (dec_region)
            RG_DOMCFG: rd_data = DOMCFG_FIXED | (32'(cfg_ie) << DOMCFG_IE_BIT);
            RG_SRCCFG: rd_data = 32'(rd_mode);
            RG_SETIP:  rd_data = pend_word;
            RG_CLRIP:  rd_data = rect_word;
            RG_SETIE:  rd_data = en_word;
            RG_GENMSG: rd_data = genmsg;
            RG_TARGET: rd_data = rd_target;
            default:   rd_data = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = (wr_q && !err_q) ? ST_KICK : ST_IDLE;
            ST_KICK: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // response and mask registers, loaded on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            wr_q  <= 1'b0;
            num_q <= 1'b0;
            rdata_q <= '0;
            gw_set_pend <= '0;
            gw_clr_pend <= '0;
            gw_set_en   <= '0;
            gw_clr_en   <= '0;
        end else begin
            gw_set_pend <= sp_d;
            gw_clr_pend <= cp_d;
            gw_set_en   <= se_d;
            gw_clr_en   <= ce_d;
            if (accept) begin
                err_q   <= bad;
                wr_q    <= req_write;
                num_q   <= is_num && req_write && !bad;
                rdata_q <= (bad || req_write) ? 32'd0 : rd_data;
            end
        end
    end

    // outputs from state
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        rescan    = (state_q == ST_KICK);
        rsp_err   = rsp_valid && err_q;
        rsp_rdata = rsp_valid ? rdata_q : 32'd0;
    end

    assert_rsp_follows_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid && !req_ready));

    assert_rescan_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && wr_q) |=> rescan);

    assert_rescan_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rescan |-> ($past(rsp_valid) && !$past(rsp_err)));

    assert_masks_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_valid) |-> ((gw_set_pend | gw_clr_pend | gw_set_en | gw_clr_en) == '0));

    assert_no_source0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(gw_set_pend[0] || gw_clr_pend[0] || gw_set_en[0] || gw_clr_en[0]));

    assert_num_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && num_q) |-> $onehot0(gw_set_pend | gw_clr_pend | gw_set_en | gw_clr_en));

    assert_err_no_effect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> ($stable(cfg_ie) && $stable(cfg_mode) && $stable(cfg_target)
            && ((gw_set_pend | gw_clr_pend | gw_set_en | gw_clr_en) == '0)));

endmodule

// File: tb/irq_reg_frontend_bench.sv
`timescale 1ns/1ps
module irq_reg_frontend_bench;
    localparam int N = 40;
    localparam int OW = 14;

    localparam int K_NONE = 0, K_DOM = 1, K_SRC = 2, K_SIP = 3, K_SIPN = 4, K_CIP = 5,
                   K_CIPN = 6, K_SIE = 7, K_SIEN = 8, K_CIE = 9, K_CIEN = 10,
                   K_LE = 11, K_BE = 12, K_GEN = 13, K_TGT = 14;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [OW-1:0] req_off = '0;
    logic [3:0] req_size = 4'd4;
    logic [31:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_err, rescan, cfg_ie;
    logic [31:0] rsp_rdata;
    logic [N-1:0] gw_set_pend, gw_clr_pend, gw_set_en, gw_clr_en;
    logic [N-1:0] gw_pend = '0, gw_en = '0, gw_raw = '0;
    logic [N*3-1:0] cfg_mode;
    logic [N*32-1:0] cfg_target;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    logic        m_ie;
    logic [2:0]  m_mode [N];
    logic [31:0] m_tgt  [N];
    logic [31:0] m_gen;

    always #2 clk = ~clk;

    irq_reg_frontend #(.NUM_IDS(N), .OFF_W(OW)) u_irq_reg_frontend (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .gw_set_pend(gw_set_pend), .gw_clr_pend(gw_clr_pend), .gw_set_en(gw_set_en),
        .gw_clr_en(gw_clr_en), .gw_pend(gw_pend), .gw_en(gw_en), .gw_raw(gw_raw),
        .cfg_ie(cfg_ie), .cfg_mode(cfg_mode), .cfg_target(cfg_target), .rescan(rescan));

    task automatic check(input string req, input bit ok, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] swap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] word_of(input logic [N-1:0] v, input int w);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++) begin
            int id = 32 * w + i;
            if (id >= 1 && id < N) r[i] = v[id];
        end
        return r;
    endfunction

    function automatic logic [N-1:0] rectified();
        logic [N-1:0] r;
        for (int s = 0; s < N; s++) begin
            if (m_mode[s] == 3'd0) r[s] = 1'b0;
            else if (m_mode[s] == 3'd5 || m_mode[s] == 3'd7) r[s] = ~gw_raw[s];
            else r[s] = gw_raw[s];
        end
        return r;
    endfunction

    function automatic logic [N-1:0] onehot(input logic [31:0] v);
        logic [N-1:0] r = '0;
        if (v >= 1 && v < N) r[v] = 1'b1;
        return r;
    endfunction

    function automatic logic [N-1:0] wmask(input int w, input logic [31:0] d);
        logic [N-1:0] r = '0;
        for (int i = 0; i < 32; i++) begin
            int id = 32 * w + i;
            if (id >= 1 && id < N && d[i]) r[id] = 1'b1;
        end
        return r;
    endfunction

    // independent offset decode: returns kind, sets element index
    function automatic int kind_of(input int o, output int ix);
        ix = 0;
        if (o == 0) return K_DOM;
        if (o >= 4 && o < 4 + (N - 1) * 4) begin ix = (o - 4) / 4 + 1; return K_SRC; end
        if (o >= 'h1C00 && o < 'h1C08) begin ix = (o - 'h1C00) / 4; return K_SIP; end
        if (o == 'h1CDC) return K_SIPN;
        if (o >= 'h1D00 && o < 'h1D08) begin ix = (o - 'h1D00) / 4; return K_CIP; end
        if (o == 'h1DDC) return K_CIPN;
        if (o >= 'h1E00 && o < 'h1E08) begin ix = (o - 'h1E00) / 4; return K_SIE; end
        if (o == 'h1EDC) return K_SIEN;
        if (o >= 'h1F00 && o < 'h1F08) begin ix = (o - 'h1F00) / 4; return K_CIE; end
        if (o == 'h1FDC) return K_CIEN;
        if (o == 'h2000) return K_LE;
        if (o == 'h2004) return K_BE;
        if (o == 'h3000) return K_GEN;
        if (o >= 'h3004 && o < 'h3004 + (N - 1) * 4) begin ix = (o - 'h3004) / 4 + 1; return K_TGT; end
        return K_NONE;
    endfunction

    function automatic string tag_of(input int k, input bit wr);
        case (k)
            K_NONE: return "R1/R10";
            K_DOM:  return "R2";
            K_SRC:  return "R3";
            K_TGT:  return "R4";
            K_CIP:  return wr ? "R7" : "R6";
            K_SIP, K_SIE, K_CIE: return wr ? "R7" : "R5";
            K_BE:   return wr ? "R9" : "R5";
            K_GEN:  return "R12";
            default: return wr ? "R8" : "R5";
        endcase
    endfunction

    task automatic run_op(input bit wr, input int off, input logic [3:0] sz,
                          input logic [31:0] wd);
        int ix, k;
        bit e_err, e_kick;
        logic [31:0] e_rd = '0;
        logic [N-1:0] e_sp = '0, e_cp = '0, e_se = '0, e_ce = '0;
        logic [N*3-1:0] e_mode;
        logic [N*32-1:0] e_tgt;
        string t;
        k = kind_of(off, ix);
        e_err = (sz != 4) || (off % 4 != 0) || (k == K_NONE);
        t = e_err ? "R1" : tag_of(k, wr);
        if (!e_err && !wr) begin
            case (k)
                K_DOM: e_rd = 32'h8000_0004 | (32'(m_ie) << 8);
                K_SRC: e_rd = 32'(m_mode[ix]);
                K_SIP: e_rd = word_of(gw_pend, ix);
                K_CIP: e_rd = word_of(rectified(), ix);
                K_SIE: e_rd = word_of(gw_en, ix);
                K_GEN: e_rd = m_gen;
                K_TGT: e_rd = m_tgt[ix];
                default: e_rd = '0;
            endcase
        end
        if (!e_err && wr) begin
            case (k)
                K_SIP: e_sp = wmask(ix, wd);
                K_SIPN, K_LE: e_sp = onehot(wd);
                K_BE: e_sp = onehot(swap(wd));
                K_CIP: e_cp = wmask(ix, wd);
                K_CIPN: e_cp = onehot(wd);
                K_SIE: e_se = wmask(ix, wd);
                K_SIEN: e_se = onehot(wd);
                K_CIE: e_ce = wmask(ix, wd);
                K_CIEN: e_ce = onehot(wd);
                K_DOM: m_ie = wd[8];
                K_SRC: m_mode[ix] = wd[10] ? 3'd0 : wd[2:0];
                K_TGT: m_tgt[ix] = wd & 32'hFFFF_F7FF;
                K_GEN: m_gen = wd & 32'hFFFC_0FFF;
                default: ;
            endcase
        end
        e_kick = wr && !e_err;
        @(negedge clk);
        check("R11 ready in idle", req_ready === 1'b1, 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_write = wr; req_off = OW'(off); req_size = sz; req_wdata = wd;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        check({"R11 response ", t}, rsp_valid === 1'b1, 64'(rsp_valid), 64'd1);
        check({t, " err"}, rsp_err === e_err, 64'(rsp_err), 64'(e_err));
        check({t, " rdata"}, rsp_rdata === e_rd, 64'(rsp_rdata), 64'(e_rd));
        check({t, " set_pend mask"}, gw_set_pend === e_sp, 64'(gw_set_pend), 64'(e_sp));
        check({t, " clr_pend mask"}, gw_clr_pend === e_cp, 64'(gw_clr_pend), 64'(e_cp));
        check({t, " set_en mask"}, gw_set_en === e_se, 64'(gw_set_en), 64'(e_se));
        check({t, " clr_en mask"}, gw_clr_en === e_ce, 64'(gw_clr_en), 64'(e_ce));
        @(negedge clk);
        check("R11 rescan", rescan === e_kick, 64'(rescan), 64'(e_kick));
        check("R11 ready after", req_ready === !e_kick, 64'(req_ready), 64'(!e_kick));
        check("R7 masks quiet", (gw_set_pend | gw_clr_pend | gw_set_en | gw_clr_en) === '0,
              64'(gw_set_pend | gw_clr_pend | gw_set_en | gw_clr_en), 64'd0);
        for (int s = 0; s < N; s++) begin
            e_mode[s*3 +: 3]  = m_mode[s];
            e_tgt[s*32 +: 32] = m_tgt[s];
        end
        check("R2 cfg_ie", cfg_ie === m_ie, 64'(cfg_ie), 64'(m_ie));
        check("R3 cfg_mode", cfg_mode === e_mode, cfg_mode[63:0], e_mode[63:0]);
        check("R4 cfg_target", cfg_target === e_tgt, cfg_target[63:0], e_tgt[63:0]);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_ie = 1'b0; m_gen = '0;
        for (int s = 0; s < N; s++) begin m_mode[s] = '0; m_tgt[s] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset rsp_valid", rsp_valid === 1'b0, 64'(rsp_valid), 64'd0);
        check("R11 reset rescan", rescan === 1'b0, 64'(rescan), 64'd0);
        check("R2 reset cfg_ie", cfg_ie === 1'b0, 64'(cfg_ie), 64'd0);
        check("R3 reset cfg_mode", cfg_mode === '0, cfg_mode[63:0], 64'd0);

        gw_pend = 40'hA5_1234_5679; gw_en = 40'h3C_F0F0_0F0F; gw_raw = 40'h96_C3A5_5A3C;
        // directed corners
        run_op(0, 'h0000, 4, 0);                 // R2 fixed read value
        run_op(1, 'h0000, 4, 32'hFFFF_FFFF);     // R2 only enable bit kept
        run_op(0, 'h0000, 4, 0);
        run_op(1, 'h0004, 4, 32'h0000_0405);     // R3 delegate bit forces 0
        run_op(1, 'h0008, 4, 32'h0000_0007);     // R3 source 2 active-low
        run_op(0, 'h0008, 4, 0);
        run_op(1, 'h000C, 4, 32'h0000_0005);     // R6 source 3 falling
        run_op(1, 'h0010, 4, 32'h0000_0006);     // source 4 high
        run_op(0, 'h1D00, 4, 0);                 // R6 rectified word 0
        run_op(0, 'h1D04, 4, 0);                 // R6 word 1
        run_op(0, 'h00A0, 4, 0);                 // R1 past last source cfg
        run_op(1, 'h3004 + 38 * 4, 4, 32'hFFFF_FFFF); // R4 last target
        run_op(0, 'h3004 + 38 * 4, 4, 0);
        run_op(0, 'h3004 + 39 * 4, 4, 0);        // R1 past last target
        run_op(1, 'h2004, 4, 32'h2100_0000);     // R9 byte swap -> source 33
        run_op(1, 'h2004, 4, 32'h0000_0021);     // R9 unswapped value out of range
        run_op(1, 'h1CDC, 4, 32'd0);             // R8 source 0 ignored
        run_op(1, 'h1EDC, 4, 32'd40);            // R8 out of range ignored
        run_op(1, 'h1FDC, 4, 32'd39);            // R8 last source
        run_op(1, 'h1C00, 4, 32'hFFFF_FFFF);     // R7 word 0 skips source 0
        run_op(1, 'h1F04, 4, 32'hFFFF_FFFF);     // R7 word 1 upper bits absent
        run_op(0, 'h1F08, 4, 0);                 // R10 word 2 unmapped
        run_op(1, 'h1C08, 4, 32'h1);             // R10
        run_op(0, 'h1F00, 4, 0);                 // R5 clear-enable reads 0
        run_op(1, 'h3000, 4, 32'hFFFF_FFFF);     // R12 guest field cleared
        run_op(0, 'h3000, 4, 0);
        run_op(1, 'h0000, 2, 32'h0);             // R1 wrong size
        run_op(1, 'h0006, 4, 32'h7);             // R1 misaligned
        run_op(1, 'h0BAC, 4, 32'h7);             // R1 unmapped

        for (int n = 0; n < 600; n++) begin
            int r = $urandom_range(0, 14);
            int off, ix;
            logic [3:0] sz = 4;
            logic [31:0] wd = $urandom;
            bit wr = $urandom_range(0, 1);
            if (n % 16 == 0) begin
                gw_pend = {$urandom, $urandom}; gw_en = {$urandom, $urandom};
                gw_raw = {$urandom, $urandom};
            end
            ix = $urandom_range(0, 2);
            case (r)
                0: off = $urandom_range(0, 'h3FFF) & ~3;
                1: off = 0;
                2: begin off = 4 + 4 * $urandom_range(0, N - 1); wd = wd & 32'h0000_0407; end
                3: off = 'h1C00 + 4 * ix;
                4: off = 'h1CDC;
                5: off = 'h1D00 + 4 * ix;
                6: off = 'h1DDC;
                7: off = 'h1E00 + 4 * ix;
                8: off = 'h1EDC;
                9: off = 'h1F00 + 4 * ix;
                10: off = 'h1FDC;
                11: off = 'h2000;
                12: off = 'h2004;
                13: off = 'h3000;
                default: off = 'h3004 + 4 * $urandom_range(0, N - 1);
            endcase
            if (r == 4 || r == 6 || r == 8 || r == 10 || r == 11) wd = $urandom_range(0, N + 3);
            if (r == 12) wd = swap($urandom_range(0, N + 3));
            if ($urandom_range(0, 19) == 0) sz = 4'($urandom_range(0, 3) * 2 + 1);
            if ($urandom_range(0, 19) == 0) off = off | $urandom_range(1, 3);
            run_op(wr, off, sz, wd);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule